// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides the outcome of floating-point conditional instructions. It reads the four result-type flags of the most recent floating-point result from a 32-bit status word. It evaluates a 6-bit predicate code against those flags and returns three things: the branch decision, the byte that a set-on-condition writes, and the counter update with branch decision for a decrement-and-loop instruction. The predicates are aware of unordered results. When the not-a-number flag is set, the negative and zero flags are ignored, so any ordered comparison comes out false.

The sequencer presents one request per cycle with `in_valid`. The request carries the predicate code, the status word and one 32-bit data register value. That register is the loop counter for decrement-and-loop and the destination for set-on-condition. All results appear together one cycle later, held in output registers and marked by `out_valid`. Predicate codes with the top bit set are rejected as illegal.

Top module: `fpcc_eval`

## Requirements
- R1: The flags are taken from the status word: not-a-number at bit 24, infinity at bit 25, zero at bit 26 and negative at bit 27. Every other status bit, and the infinity flag, has no effect on any output.
- R2: When the not-a-number flag is set, negative and zero are treated as clear. The result of a legal code is then equal to bit 3 of the code.
- R3: Code 0x00 is always false and code 0x0F is always true. 0x01 is zero, 0x0E is not zero, 0x07 is not not-a-number and 0x08 is not-a-number.
- R4: Code 0x02 is true when not-a-number, zero and negative are all clear. 0x03 is zero or not(not-a-number or negative). 0x04 is negative and not(not-a-number or zero). 0x05 is zero or (negative and not not-a-number). 0x06 is not(not-a-number or zero).
- R5: Code 0x09 is not-a-number or zero. 0x0A is not-a-number or not(negative or zero). 0x0B is not-a-number or zero or not negative. 0x0C is not-a-number or (negative and not zero). 0x0D is not-a-number or zero or negative.
- R6: Codes 0x10 to 0x1F give the same result as the code 16 lower.
- R7: A code with bit 5 set raises `out_illegal`. For such a code the predicate result is 0, the set byte is 0x00, the loop branch is 0, and both register outputs equal the input register unchanged.
- R8: For a legal code, the set byte is 0xFF when the predicate is true and 0x00 when it is false. `out_set_reg` is the input register with only bits 7:0 replaced by that byte.
- R9: For a legal code with a false predicate, the counter output keeps bits 31:16 and holds bits 15:0 minus one, modulo 2^16. The loop branch is 1 exactly when the new low half is 0xFFFF.
- R10: For a legal code with a true predicate, the counter output equals the input register and the loop branch is 0.
- R11: Results appear one clock after the request. `out_valid` is high for exactly the cycles after an `in_valid` cycle. Data outputs hold between requests. A synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| pred_code | input | 6 | Predicate code |
| st_word | input | 32 | Status word holding the result flags |
| reg_in | input | 32 | Loop counter / set destination register value |
| out_valid | output | 1 | Results valid strobe |
| out_true | output | 1 | Predicate result (branch taken) |
| out_illegal | output | 1 | Predicate code out of range |
| out_set_byte | output | 8 | Byte for set-on-condition |
| out_set_reg | output | 32 | Register after set-on-condition |
| out_cnt | output | 32 | Counter after decrement-and-loop |
| out_loop_br | output | 1 | Decrement-and-loop branch taken |

## Verification
Set-on-condition and decrement-and-loop are both derived from the same predicate in the same cycle, and both overwrite part of the same register value. The bench therefore gives requests whose register low half is 0x0000, 0x0001 or 0xFFFF, with upper bits that differ from the low byte, under both true and false predicates. One cycle then shows the counter wrapping to 0xFFFF with the loop branch taken, while the set byte reads 0x00 and only the low byte of the register is replaced. Each output field is compared on every clock against a model that classifies the flags into a relation (equal, greater, less, unordered) and selects one bit of the code.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  localparam int ST_NAN_POS  = 24;
  localparam int ST_INF_POS  = 25;
  localparam int ST_ZERO_POS = 26;
  localparam int ST_NEG_POS  = 27;

  typedef struct packed {
    logic neg;
    logic zero;
    logic inf;
    logic nan;
  } cc_flags_t;

  // Predicate on already-masked flags; sel is the code modulo 16.
  function automatic logic cc_pred(input logic [3:0] sel, input cc_flags_t f);
    logic n, z, u, r;
    n = f.neg;
    z = f.zero;
    u = f.nan;
    case (sel)
      4'h0: r = 1'b0;
      4'h1: r = z;
      4'h2: r = ~(u | z | n);
      4'h3: r = z | ~(u | n);
      4'h4: r = n & ~(u | z);
      4'h5: r = z | (n & ~u);
      4'h6: r = ~(u | z);
      4'h7: r = ~u;
      4'h8: r = u;
      4'h9: r = u | z;
      4'hA: r = u | ~(n | z);
      4'hB: r = u | z | ~n;
      4'hC: r = u | (n & ~z);
      4'hD: r = u | z | n;
      4'hE: r = ~z;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpcc_flags.sv
module fpcc_flags #(
  parameter int ST_W = 32
) (
  input  logic [ST_W-1:0]        st_word,
  output fpcc_pkg::cc_flags_t    cc
);
  localparam logic [ST_W-1:0] KEEP_MASK =
    (ST_W'(1) << fpcc_pkg::ST_NAN_POS)  | (ST_W'(1) << fpcc_pkg::ST_INF_POS) |
    (ST_W'(1) << fpcc_pkg::ST_ZERO_POS) | (ST_W'(1) << fpcc_pkg::ST_NEG_POS);

  logic nan_bit;
  logic unused_st;

  assign nan_bit   = st_word[fpcc_pkg::ST_NAN_POS];
  assign unused_st = ^(st_word & ~KEEP_MASK);

  // Unordered result hides sign and zero from every predicate.
  always_comb begin
    cc.nan  = nan_bit;
    cc.inf  = st_word[fpcc_pkg::ST_INF_POS];
    cc.neg  = st_word[fpcc_pkg::ST_NEG_POS]  & ~nan_bit;
    cc.zero = st_word[fpcc_pkg::ST_ZERO_POS] & ~nan_bit;
  end
endmodule

// File: rtl/fpcc_pred.sv
module fpcc_pred #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0]   code,
  input  fpcc_pkg::cc_flags_t cc,
  output logic                hit,
  output logic                illegal
);
  localparam int TBL_N = 2 ** (CODE_W - 1);
  localparam int SEL_W = 4;

  logic [TBL_N-1:0] tbl;
  logic             unused_inf;

  assign unused_inf = cc.inf;

  // Legal half of the code space; index truncation folds the upper 16 onto the lower.
  for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
    assign tbl[i] = fpcc_pkg::cc_pred(SEL_W'(i), cc);
  end

  assign illegal = code[CODE_W-1];
  assign hit     = ~illegal & tbl[code[CODE_W-2:0]];
endmodule

// File: rtl/fpcc_loop.sv
module fpcc_loop #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic [DATA_W-1:0] reg_in,
  input  logic              legal,
  input  logic              hit,
  output logic [DATA_W-1:0] cnt_next,
  output logic              loop_br
);
  logic [CNT_W-1:0] low_dec;

  assign low_dec = reg_in[CNT_W-1:0] - CNT_W'(1);

  always_comb begin
    if (legal && !hit) begin
      cnt_next = {reg_in[DATA_W-1:CNT_W], low_dec};
      loop_br  = &low_dec;
    end else begin
      cnt_next = reg_in;
      loop_br  = 1'b0;
    end
  end
endmodule

// File: rtl/fpcc_eval.sv
module fpcc_eval #(
  parameter int CODE_W = 6,
  parameter int ST_W   = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] pred_code,
  input  logic [ST_W-1:0]   st_word,
  input  logic [DATA_W-1:0] reg_in,
  output logic              out_valid,
  output logic              out_true,
  output logic              out_illegal,
  output logic [BYTE_W-1:0] out_set_byte,
  output logic [DATA_W-1:0] out_set_reg,
  output logic [DATA_W-1:0] out_cnt,
  output logic              out_loop_br
);
  fpcc_pkg::cc_flags_t cc;
  logic              hit, illegal;
  logic [DATA_W-1:0] cnt_nx, set_reg_nx;
  logic [BYTE_W-1:0] set_byte_nx;
  logic              loop_br_nx;

  fpcc_flags #(.ST_W(ST_W)) u_flags (
    .st_word (st_word),
    .cc      (cc)
  );

  fpcc_pred #(.CODE_W(CODE_W)) u_pred (
    .code    (pred_code),
    .cc      (cc),
    .hit     (hit),
    .illegal (illegal)
  );

  fpcc_loop #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_loop (
    .reg_in   (reg_in),
    .legal    (~illegal),
    .hit      (hit),
    .cnt_next (cnt_nx),
    .loop_br  (loop_br_nx)
  );

  always_comb begin
    set_byte_nx = hit ? {BYTE_W{1'b1}} : '0;
    set_reg_nx  = illegal ? reg_in : {reg_in[DATA_W-1:BYTE_W], set_byte_nx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_true     <= 1'b0;
      out_illegal  <= 1'b0;
      out_set_byte <= '0;
      out_set_reg  <= '0;
      out_cnt      <= '0;
      out_loop_br  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_true     <= hit;
        out_illegal  <= illegal;
        out_set_byte <= set_byte_nx;
        out_set_reg  <= set_reg_nx;
        out_cnt      <= cnt_nx;
        out_loop_br  <= loop_br_nx;
      end
    end
  end

  AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_illegal && $past(st_word[fpcc_pkg::ST_NAN_POS]) |-> out_true == $past(pred_code[3])); // R2
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> !out_true && out_set_byte == '0 && !out_loop_br); // R7
  AST_SET_BYTE_FILL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_illegal |-> out_set_byte == {BYTE_W{out_true}}); // R8
  AST_SET_REG_UPPER: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_set_reg[DATA_W-1:BYTE_W] == $past(reg_in[DATA_W-1:BYTE_W])); // R8
  AST_CNT_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_cnt[DATA_W-1:CNT_W] == $past(reg_in[DATA_W-1:CNT_W])); // R9
  AST_LOOP_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_loop_br |-> &out_cnt[CNT_W-1:0]); // R9
  AST_TRUE_NO_LOOP: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_true |-> !out_loop_br && out_cnt == $past(reg_in)); // R10
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R11
endmodule

// File: tb/fpcc_eval_bench.sv
module fpcc_eval_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  pred_code = '0;
  logic [31:0] st_word = '0;
  logic [31:0] reg_in = '0;
  logic        out_valid, out_true, out_illegal, out_loop_br;
  logic [7:0]  out_set_byte;
  logic [31:0] out_set_reg, out_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected outputs (behavioural model state)
  logic        e_valid = 0, e_true = 0, e_ill = 0, e_br = 0;
  logic [7:0]  e_byte = 0;
  logic [31:0] e_sreg = 0, e_cnt = 0;
  string       e_tag = "R11";

  always #10 clk = ~clk;

  fpcc_eval u_fpcc_eval (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pred_code(pred_code),
    .st_word(st_word), .reg_in(reg_in), .out_valid(out_valid), .out_true(out_true),
    .out_illegal(out_illegal), .out_set_byte(out_set_byte), .out_set_reg(out_set_reg),
    .out_cnt(out_cnt), .out_loop_br(out_loop_br)
  );

  // Relation view: code bit0 equal, bit1 greater, bit2 less, bit3 unordered.
  function automatic logic ref_true(logic [5:0] c, logic [31:0] s);
    int rel;
    if (c[5]) return 1'b0;
    if (s[24])      rel = 3;
    else if (s[26]) rel = 0;
    else if (s[27]) rel = 2;
    else            rel = 1;
    return c[rel];
  endfunction

  function automatic string pred_tag(logic [5:0] c, logic [31:0] s);
    int lo = int'(c[3:0]);
    if (c[5]) return "R7";
    if ((s & ~32'h0F00_0000) != 0 || s[25]) return "R1";
    if (c[4]) return "R6";
    if (s[24]) return "R2";
    if (lo == 0 || lo == 15 || lo == 1 || lo == 14 || lo == 7 || lo == 8) return "R3";
    if (lo >= 2 && lo <= 6) return "R4";
    return "R5";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs, update model, check after the capturing edge.
  task automatic step(logic r, logic v, logic [5:0] c, logic [31:0] s, logic [31:0] d);
    int lo;
    logic t;
    rst = r; in_valid = v; pred_code = c; st_word = s; reg_in = d;
    @(negedge clk);
    if (r) begin
      e_valid = 0; e_true = 0; e_ill = 0; e_br = 0; e_byte = 0; e_sreg = 0; e_cnt = 0;
      e_tag = "R11";
    end else begin
      e_valid = v;
      if (v) begin
        t      = ref_true(c, s);
        e_true = t;
        e_ill  = c[5];
        e_tag  = pred_tag(c, s);
        e_byte = t ? 8'hFF : 8'h00;
        e_sreg = c[5] ? d : ((d & 32'hFFFF_FF00) | {24'h0, e_byte});
        if (!c[5] && !t) begin
          lo    = (int'(d[15:0]) + 65535) % 65536;
          e_cnt = (d & 32'hFFFF_0000) | lo;
          e_br  = (lo == 65535);
        end else begin
          e_cnt = d;
          e_br  = 0;
        end
      end
    end
    chk("R11", "out_valid", 32'(out_valid), 32'(e_valid));
    chk("R7", "out_illegal", 32'(out_illegal), 32'(e_ill));
    chk(e_tag, "out_true", 32'(out_true), 32'(e_true));
    chk("R8", "out_set_byte", 32'(out_set_byte), 32'(e_byte));
    chk("R8", "out_set_reg", out_set_reg, e_sreg);
    chk(e_true ? "R10" : "R9", "out_cnt", out_cnt, e_cnt);
    chk("R9", "out_loop_br", 32'(out_loop_br), 32'(e_br));
  endtask

  initial begin
    logic [31:0] pats [7];
    pats[0] = 32'h0000_0000;   // greater
    pats[1] = 32'h0400_0000;   // zero
    pats[2] = 32'h0800_0000;   // negative
    pats[3] = 32'h0C00_0000;   // negative and zero
    pats[4] = 32'h0100_0000;   // unordered
    pats[5] = 32'h0D00_0000;   // unordered with N and Z
    pats[6] = 32'hF2FF_FFFF;   // infinity plus noise, ordered greater (R1)
    @(negedge clk);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);                              // reset state, R11
    for (int p = 0; p < 7; p++) begin
      for (int c = 0; c < 64; c++) begin
        step(0, 1, 6'(c), pats[p], {16'hA5C3, 8'(c), 8'(p * 37 + 1)});
      end
      step(0, 0, 6'h0F, pats[p], 32'hDEAD_BEEF);      // hold between requests, R11
    end
    // Same-cycle set and loop corners: wrap, reach zero, from all ones (R8 R9 R10)
    step(0, 1, 6'h00, 32'h0, 32'h1234_0000);
    step(0, 1, 6'h10, 32'h0, 32'h8765_0001);
    step(0, 1, 6'h01, 32'h0, 32'hFFFF_FFFF);
    step(0, 1, 6'h0F, 32'h0100_0000, 32'h0000_0000);
    step(0, 1, 6'h02, 32'h0100_0000, 32'h5A5A_0000);  // R2 unordered false, wraps
    step(0, 1, 6'h2F, 32'h0, 32'h0000_0000);          // R7 illegal leaves counter
    step(1, 1, 6'h00, 32'h0, 32'h0000_0000);          // R11 reset clears outputs
    step(0, 0, 6'h00, 32'h0, 32'h0000_0000);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule